// File: doc/BRIEF.md
# Four-lane byte/word FIFO buffer

This block holds the data that passes between a host bus and the serial shifter of a flash or SPI-style controller. Each direction is made of four byte-wide lanes of equal depth. Through the 32-bit word port every push or pop moves one byte in all four lanes in the same cycle, so a direction holds four times the lane depth in bytes. Through the byte port only lane 0 moves, so the same storage holds just one lane depth of bytes.

The transmit direction is filled by the host and drained by the shifter. The receive direction is filled by the shifter and drained by the host. Both directions report occupancy flags that an interrupt status block can use. The receive side has two separate flags that tell the host when a whole word can be read and when at least one byte can be read. A request that cannot be served is dropped and raises a one-cycle illegal-access pulse. A synchronous soft reset empties both directions.

Top module: `quad_lane_fifo`

## Requirements
- R1: A word push puts wdata bits 8k+7:8k into lane k (k = 0..3). The read data always shows the four lane heads in that same byte order, so words come back in the order they were pushed.
- R2: Through the word port a direction accepts DEPTH words. Once it holds DEPTH words its full flag is 1, and a further word push is dropped.
- R3: The byte port writes wdata[7:0] into lane 0 only and pops lane 0 only, with the popped byte on rdata[7:0]. Lane 0 holds DEPTH bytes, and after DEPTH byte pushes the full flag is 1.
- R4: The transmit flags are decoded from the four lane counts. Full is 1 when any lane holds DEPTH entries. Half is 1 when any lane holds at least DEPTH/2. Empty is 1 only when all lanes are empty.
- R5: rx_word_avail is 1 only while all four receive lanes hold data. rx_byte_avail is 1 while receive lane 0 holds data.
- R6: A push is dropped, and ill_access is 1 for the next cycle, in two cases: its target lane is full, or the word and byte push strobes of a direction are both set.
- R7: A pop is dropped, and ill_access is 1 for the next cycle, in two cases: its lanes do not all hold data, or the word and byte pop strobes are both set. The stored contents stay unchanged.
- R8: A push and a pop on the same direction in the same cycle are each judged against the counts held before that cycle, and both take effect when legal.
- R9: After rst_n or a cycle with soft_rst high, every lane is empty and ill_access is 0.
- R10: The receive direction stores and flags data in the same way as the transmit direction, with rx_full and rx_half decoded as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of all lanes |
| tx_wr_word | input | 1 | Host pushes one word into transmit |
| tx_wr_byte | input | 1 | Host pushes one byte into transmit lane 0 |
| tx_wdata | input | 32 | Transmit push data |
| tx_rd_word | input | 1 | Shifter pops one word from transmit |
| tx_rd_byte | input | 1 | Shifter pops one byte from transmit lane 0 |
| tx_rdata | output | 32 | Transmit lane heads |
| tx_full | output | 1 | Some transmit lane is full |
| tx_half | output | 1 | Some transmit lane is at least half full |
| tx_empty | output | 1 | All transmit lanes are empty |
| rx_wr_word | input | 1 | Shifter pushes one word into receive |
| rx_wr_byte | input | 1 | Shifter pushes one byte into receive lane 0 |
| rx_wdata | input | 32 | Receive push data |
| rx_rd_word | input | 1 | Host pops one word from receive |
| rx_rd_byte | input | 1 | Host pops one byte from receive lane 0 |
| rx_rdata | output | 32 | Receive lane heads |
| rx_full | output | 1 | Some receive lane is full |
| rx_half | output | 1 | Some receive lane is at least half full |
| rx_word_avail | output | 1 | Whole word readable |
| rx_byte_avail | output | 1 | At least one byte readable |
| ill_access | output | 1 | One-cycle pulse after a dropped request |

## Verification
The bench builds the block with DEPTH set to 4. With that depth, filling a direction through the word port takes four pushes and filling lane 0 through the byte port takes four. This makes it cheap to reach the full boundary, the half threshold at two entries, and the pointer wrap after a full drain. With so few entries, mixed byte and word traffic can leave lane 0 deeper than the other lanes within a handful of cycles, which shows the split between the word and byte availability flags.

// File: rtl/quad_lane_fifo.sv
`timescale 1ns/1ps
module quad_lane_fifo #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        tx_wr_word,
  input  logic        tx_wr_byte,
  input  logic [31:0] tx_wdata,
  input  logic        tx_rd_word,
  input  logic        tx_rd_byte,
  output logic [31:0] tx_rdata,
  output logic        tx_full,
  output logic        tx_half,
  output logic        tx_empty,
  input  logic        rx_wr_word,
  input  logic        rx_wr_byte,
  input  logic [31:0] rx_wdata,
  input  logic        rx_rd_word,
  input  logic        rx_rd_byte,
  output logic [31:0] rx_rdata,
  output logic        rx_full,
  output logic        rx_half,
  output logic        rx_word_avail,
  output logic        rx_byte_avail,
  output logic        ill_access
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]       wr_w, wr_b, rd_w, rd_b;
  logic [1:0][31:0] wd, rd;
  logic [1:0]       full, half, nonempty, all_nz, bad;

  assign wr_w = {rx_wr_word, tx_wr_word};
  assign wr_b = {rx_wr_byte, tx_wr_byte};
  assign rd_w = {rx_rd_word, tx_rd_word};
  assign rd_b = {rx_rd_byte, tx_rd_byte};
  assign wd   = {rx_wdata, tx_wdata};

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [3:0] lfull, lnz, lhalf;
    logic push_ok, pop_ok;

    assign push_ok = (wr_w[d] ^ wr_b[d]) & (wr_w[d] ? ~|lfull : ~lfull[0]);
    assign pop_ok  = (rd_w[d] ^ rd_b[d]) & (rd_w[d] ? &lnz : lnz[0]);
    assign bad[d]  = ((wr_w[d] | wr_b[d]) & ~push_ok) | ((rd_w[d] | rd_b[d]) & ~pop_ok);

    for (genvar k = 0; k < 4; k++) begin : g_lane
      logic [7:0]    mem [DEPTH];
      logic [AW-1:0] wp, rp;
      logic [CW-1:0] cnt;
      logic          pe, qe;

      assign pe = push_ok & (wr_w[d] | (k == 0));
      assign qe = pop_ok  & (rd_w[d] | (k == 0));

      always_ff @(posedge clk)
        if (pe) mem[wp] <= wd[d][8*k +: 8];

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          wp <= '0; rp <= '0; cnt <= '0;
        end else if (soft_rst) begin
          wp <= '0; rp <= '0; cnt <= '0;
        end else begin
          if (pe) wp <= wp + AW'(1);
          if (qe) rp <= rp + AW'(1);
          cnt <= cnt + CW'(pe) - CW'(qe);
        end

      assign lfull[k] = (cnt == CW'(DEPTH));
      assign lhalf[k] = (cnt >= CW'(DEPTH / 2));
      assign lnz[k]   = (cnt != '0);
      assign rd[d][8*k +: 8] = mem[rp];
    end

    assign full[d]     = |lfull;
    assign half[d]     = |lhalf;
    assign nonempty[d] = lnz[0];
    assign all_nz[d]   = &lnz;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ill_access <= 1'b0;
    else if (soft_rst) ill_access <= 1'b0;
    else               ill_access <= |bad;

  assign tx_rdata      = rd[0];
  assign rx_rdata      = rd[1];
  assign tx_full       = full[0];
  assign tx_half       = half[0];
  assign tx_empty      = ~|{g_dir[0].lnz};
  assign rx_full       = full[1];
  assign rx_half       = half[1];
  assign rx_word_avail = all_nz[1];
  assign rx_byte_avail = nonempty[1];
endmodule

// File: rtl/quad_lane_fifo_chk.sv
`timescale 1ns/1ps
module quad_lane_fifo_chk (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic tx_wr_word,
  input logic tx_wr_byte,
  input logic tx_rd_word,
  input logic tx_rd_byte,
  input logic tx_full,
  input logic tx_half,
  input logic tx_empty,
  input logic rx_wr_word,
  input logic rx_wr_byte,
  input logic rx_full,
  input logic rx_word_avail,
  input logic rx_byte_avail,
  input logic ill_access
);
  assert_full_not_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_empty);
  assert_full_has_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> tx_half);
  assert_word_needs_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_avail |-> rx_byte_avail);
  assert_push_full_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_word && !tx_wr_byte && tx_full && !soft_rst) |=> ill_access);
  assert_dual_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wr_word && rx_wr_byte && !soft_rst) |=> ill_access);
  assert_pop_empty_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rd_byte && !tx_rd_word && tx_empty && !soft_rst) |=> ill_access);
  assert_empty_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !tx_wr_word && !tx_wr_byte) |=> tx_empty);
  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tx_empty && !rx_byte_avail && !rx_full && !ill_access));
  assert_rx_full_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> rx_byte_avail);
endmodule

bind quad_lane_fifo quad_lane_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
  .tx_wr_word(tx_wr_word), .tx_wr_byte(tx_wr_byte),
  .tx_rd_word(tx_rd_word), .tx_rd_byte(tx_rd_byte),
  .tx_full(tx_full), .tx_half(tx_half), .tx_empty(tx_empty),
  .rx_wr_word(rx_wr_word), .rx_wr_byte(rx_wr_byte),
  .rx_full(rx_full), .rx_word_avail(rx_word_avail),
  .rx_byte_avail(rx_byte_avail), .ill_access(ill_access)
);

// File: tb/sim_quad_lane_fifo.sv
`timescale 1ns/1ps
module sim_quad_lane_fifo;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic tx_wr_word = 0, tx_wr_byte = 0, tx_rd_word = 0, tx_rd_byte = 0;
  logic rx_wr_word = 0, rx_wr_byte = 0, rx_rd_word = 0, rx_rd_byte = 0;
  logic [31:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
  logic tx_full, tx_half, tx_empty, rx_full, rx_half, rx_word_avail, rx_byte_avail, ill_access;

  int total = 0, failed = 0;
  bit done = 0;

  always #5 clk = ~clk;

  quad_lane_fifo #(.DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic tx_push_w(input logic [31:0] w);
    tx_wr_word = 1; tx_wdata = w; @(negedge clk); tx_wr_word = 0;
  endtask
  task automatic tx_push_b(input logic [7:0] b);
    tx_wr_byte = 1; tx_wdata = {24'h0, b}; @(negedge clk); tx_wr_byte = 0;
  endtask
  task automatic tx_pop_w();
    tx_rd_word = 1; @(negedge clk); tx_rd_word = 0;
  endtask
  task automatic tx_pop_b();
    tx_rd_byte = 1; @(negedge clk); tx_rd_byte = 0;
  endtask
  task automatic rx_push_w(input logic [31:0] w);
    rx_wr_word = 1; rx_wdata = w; @(negedge clk); rx_wr_word = 0;
  endtask
  task automatic rx_push_b(input logic [7:0] b);
    rx_wr_byte = 1; rx_wdata = {24'h0, b}; @(negedge clk); rx_wr_byte = 0;
  endtask
  task automatic rx_pop_w();
    rx_rd_word = 1; @(negedge clk); rx_rd_word = 0;
  endtask
  task automatic rx_pop_b();
    rx_rd_byte = 1; @(negedge clk); rx_rd_byte = 0;
  endtask

  task automatic t_reset();
    eq("R9 tx_empty after reset", tx_empty, 1);
    eq("R9 tx_full after reset", tx_full, 0);
    eq("R9 rx_byte_avail after reset", rx_byte_avail, 0);
    eq("R9 ill_access after reset", ill_access, 0);
  endtask

  task automatic t_word_order();
    tx_push_w(32'h11223344);
    eq("R4 half at 1 entry", tx_half, 0);
    eq("R4 empty at 1 entry", tx_empty, 0);
    tx_push_w(32'hA1B2C3D4);
    eq("R4 half at 2 entries", tx_half, 1);
    tx_push_w(32'h0F1E2D3C);
    eq("R1 head word 0", tx_rdata, 32'h11223344);
    tx_pop_w();
    eq("R1 head word 1", tx_rdata, 32'hA1B2C3D4);
    tx_pop_w();
    eq("R1 head word 2", tx_rdata, 32'h0F1E2D3C);
    tx_pop_w();
    eq("R4 empty after drain", tx_empty, 1);
  endtask

  task automatic t_word_full();
    for (int i = 0; i < DEPTH; i++) tx_push_w(32'hC0DE0000 + i);
    eq("R2 full after DEPTH words", tx_full, 1);
    eq("R2 no ill on legal fill", ill_access, 0);
    tx_push_w(32'hDEADBEEF);
    eq("R6 ill after push to full", ill_access, 1);
    idle();
    eq("R6 ill is a single pulse", ill_access, 0);
    for (int i = 0; i < DEPTH; i++) begin
      eq("R2 word kept after dropped push", tx_rdata, 32'hC0DE0000 + i);
      tx_pop_w();
    end
    eq("R2 empty after DEPTH pops", tx_empty, 1);
  endtask

  task automatic t_byte_lane();
    for (int i = 0; i < DEPTH; i++) tx_push_b(8'h50 + i);
    eq("R3 full after DEPTH bytes", tx_full, 1);
    tx_push_w(32'h12345678);
    eq("R6 word push into full lane 0", ill_access, 1);
    for (int i = 0; i < DEPTH; i++) begin
      eq("R3 byte order on lane 0", tx_rdata[7:0], 8'h50 + i);
      tx_pop_b();
    end
    eq("R3 empty after byte drain", tx_empty, 1);
  endtask

  task automatic t_rx_avail();
    rx_push_b(8'h9A);
    eq("R5 byte avail after byte", rx_byte_avail, 1);
    eq("R5 no word with lane 0 only", rx_word_avail, 0);
    rx_pop_w();
    eq("R7 word pop without word", ill_access, 1);
    eq("R7 byte kept after dropped pop", rx_rdata[7:0], 8'h9A);
    rx_push_w(32'h55667788);
    eq("R5 word avail with all lanes", rx_word_avail, 1);
    eq("R1 mixed head word", rx_rdata, 32'h5566779A);
    rx_pop_w();
    eq("R5 word gone, lanes 1-3 empty", rx_word_avail, 0);
    eq("R5 lane 0 still holds a byte", rx_byte_avail, 1);
    eq("R3 leftover low byte", rx_rdata[7:0], 8'h88);
    rx_pop_b();
    eq("R5 byte avail cleared", rx_byte_avail, 0);
    for (int i = 0; i < DEPTH; i++) begin
      rx_push_w(32'h0A0B0C00 + i);
      if (i == 1) eq("R10 rx half at 2", rx_half, 1);
    end
    eq("R10 rx full", rx_full, 1);
    for (int i = 0; i < DEPTH; i++) begin
      eq("R10 rx word order", rx_rdata, 32'h0A0B0C00 + i);
      rx_pop_w();
    end
    eq("R10 rx drained", rx_byte_avail, 0);
  endtask

  task automatic t_pop_empty();
    tx_pop_b();
    eq("R7 ill on pop from empty", ill_access, 1);
    eq("R7 still empty", tx_empty, 1);
    tx_push_b(8'h3C);
    tx_rd_word = 1; tx_rd_byte = 1; @(negedge clk); tx_rd_word = 0; tx_rd_byte = 0;
    eq("R7 ill on dual pop strobe", ill_access, 1);
    eq("R7 byte kept after dual pop", tx_rdata[7:0], 8'h3C);
    tx_pop_b();
    eq("R7 empty after legal pop", tx_empty, 1);
  endtask

  task automatic t_both_strobes();
    tx_wr_word = 1; tx_wr_byte = 1; tx_wdata = 32'hFFFFFFFF;
    @(negedge clk); tx_wr_word = 0; tx_wr_byte = 0;
    eq("R6 ill on dual push strobe", ill_access, 1);
    eq("R6 nothing stored", tx_empty, 1);
  endtask

  task automatic t_simul();
    for (int i = 0; i < DEPTH; i++) tx_push_w(32'hAB000000 + i);
    tx_wr_word = 1; tx_rd_word = 1; tx_wdata = 32'hEEEE0001;
    @(negedge clk); tx_wr_word = 0; tx_rd_word = 0;
    eq("R8 push at full dropped", ill_access, 1);
    eq("R8 pop at full taken", tx_full, 0);
    eq("R8 head advanced", tx_rdata, 32'hAB000001);
    tx_wr_word = 1; tx_rd_word = 1; tx_wdata = 32'hEEEE0002;
    @(negedge clk); tx_wr_word = 0; tx_rd_word = 0;
    eq("R8 both legal, no ill", ill_access, 0);
    eq("R8 count unchanged", tx_full, 0);
    eq("R8 head after push+pop", tx_rdata, 32'hAB000002);
    tx_pop_w(); tx_pop_w();
    eq("R8 pushed word arrives last", tx_rdata, 32'hEEEE0002);
    tx_pop_w();
    eq("R8 drained", tx_empty, 1);
  endtask

  task automatic t_soft();
    tx_push_w(32'h1); tx_push_w(32'h2); rx_push_w(32'h3);
    tx_pop_b(); tx_pop_b(); tx_pop_b();
    soft_rst = 1; @(negedge clk); soft_rst = 0;
    eq("R9 tx empty after soft reset", tx_empty, 1);
    eq("R9 rx empty after soft reset", rx_byte_avail, 0);
    eq("R9 ill cleared by soft reset", ill_access, 0);
    tx_push_w(32'h77665544);
    eq("R9 pointers restart", tx_rdata, 32'h77665544);
    tx_pop_w();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    t_reset();
    t_word_order();
    t_word_full();
    t_byte_lane();
    t_rx_avail();
    t_pop_empty();
    t_both_strobes();
    t_simul();
    t_soft();
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule